// File: doc/BRIEF.md
# Effective address write-back unit

This unit takes one decoded "compute address into register" operation per cycle and produces, one clock later, a register write carrying the offset part of the memory operand's address. It does not touch memory. The upstream decoder supplies the mode byte and the scale-index byte. It also supplies a raw displacement and the current contents of the eight 32-bit general registers. The unit forms the address with either the 16-bit or the 32-bit addressing rules. It then fits the result to the destination width. The destination width and the address width are chosen independently, so there are four size pairs to handle.

A register-direct mode byte does not name a memory operand. The unit rejects it with an invalid-operation pulse and does not write anything. A small three-state controller tracks the cycle after each accepted input. Its states are ST_IDLE, ST_WRITE and ST_FAULT. From every state the next state is chosen the same way:
- ST_WRITE when `in_valid` is high and the mode field is not 11.
- ST_FAULT when `in_valid` is high and the mode field is 11.
- ST_IDLE when `in_valid` is low.

`wr_valid` is decoded from ST_WRITE and `ud_fault` from ST_FAULT.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is asserted and after it is released with no input, `wr_valid` and `ud_fault` are 0.
- R2: An input accepted with `in_valid`=1 and mode field `mode_byte[7:6]` other than 11 gives `wr_valid`=1 for exactly the following cycle. Back-to-back inputs give back-to-back pulses.
- R3: `wr_idx` equals the destination field `mode_byte[5:3]` of the accepted input.
- R4: 16-bit addressing uses the r/m field `mode_byte[2:0]` to pick the address terms, which are summed modulo 2^16:
  - 0 gives reg3+reg6, 1 gives reg3+reg7, 2 gives reg5+reg6, 3 gives reg5+reg7.
  - 4 gives reg6, 5 gives reg7, 6 gives reg5, 7 gives reg3.
  - Only the low 16 bits of each register are used.
  - Mode 01 adds `disp[7:0]` sign-extended, mode 10 adds `disp[15:0]`, and mode 00 adds nothing.
- R5: In 16-bit addressing, mode 00 with r/m 110 gives `disp[15:0]` alone, with no register term.
- R6: 32-bit addressing with r/m other than 100 uses the register named by r/m plus the displacement, summed modulo 2^32:
  - Mode 01 adds `disp[7:0]` sign-extended, mode 10 adds `disp`, and mode 00 adds nothing.
  - Mode 00 with r/m 101 gives `disp` alone.
- R7: 32-bit addressing with r/m 100 reads the scale-index byte `sx_byte` and adds base + (index << scale) + displacement:
  - The scale is `sx_byte[7:6]`, the index is `sx_byte[5:3]` and the base is `sx_byte[2:0]`.
  - An index of 100 means no index term.
  - A base of 101 in mode 00 means no base, and `disp` is added in full.
- R8: With a 16-bit destination (`op32`=0) and 32-bit addressing, the low 16 bits of the 32-bit address are written.
- R9: With a 32-bit destination and 16-bit addressing, the 16-bit address is zero-extended, so `wr_data[31:16]`=0.
- R10: `wr_be` is 1111 for a 32-bit destination. For a 16-bit destination it is 0011, and `wr_data[31:16]` repeats the destination register's current upper half.
- R11: An input with mode 11 gives `ud_fault`=1 for exactly the following cycle, with `wr_valid`=0.
- R12: Cycles with `in_valid`=0 give neither pulse, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op32 | input | 1 | Destination width: 1 = 32-bit, 0 = 16-bit |
| addr32 | input | 1 | Address width: 1 = 32-bit, 0 = 16-bit |
| mode_byte | input | 8 | Mode [7:6], destination [5:3], r/m [2:0] |
| sx_byte | input | 8 | Scale [7:6], index [5:3], base [2:0] |
| disp | input | 32 | Raw displacement, low byte used for 8-bit forms |
| gpr_flat | input | 256 | Register n occupies bits [32n+31:32n] |
| wr_valid | output | 1 | Register write pulse |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | 32 | Value to write |
| wr_be | output | 4 | Byte enables of the write |
| ud_fault | output | 1 | Invalid-operation pulse |

## Verification
A controller stuck in ST_WRITE or ST_FAULT shows on the first idle cycle as an extra pulse. A missed transition shows as a missing pulse one cycle after the input. A wrong term selection or a wrong width decision in the address path shows in `wr_data` on the very pulse of the affected operation. This is why every addressing form is driven under each size pair it belongs to. The bench also checks that the pulse falls again one cycle later, so stuck states cannot hide behind back-to-back traffic.

// File: rtl/eau_pkg.sv
package eau_pkg;
    localparam int RIDX_W = 3;
    localparam int NREG   = 1 << RIDX_W;
    localparam int DW     = 32;
    localparam int HW     = DW / 2;
    localparam int BEW    = DW / 8;

    localparam logic [1:0] MD_NODISP = 2'b00;
    localparam logic [1:0] MD_DISP8  = 2'b01;
    localparam logic [1:0] MD_DISPW  = 2'b10;
    localparam logic [1:0] MD_REG    = 2'b11;

    localparam logic [2:0] RM_SCALED = 3'b100;
    localparam logic [2:0] RM_NOBASE = 3'b101;
    localparam logic [2:0] RM_DIR16  = 3'b110;
    localparam logic [2:0] IX_NONE   = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAULT = 2'd2
    } eau_state_e;
endpackage

// File: rtl/eau_ea16.sv
module eau_ea16
    import eau_pkg::*;
(
    input  logic [1:0]    md,
    input  logic [2:0]    rm,
    input  logic [HW-1:0] disp_w,
    input  logic [HW-1:0] base_a,
    input  logic [HW-1:0] base_b,
    input  logic [HW-1:0] idx_a,
    input  logic [HW-1:0] idx_b,
    output logic [HW-1:0] ea
);
    logic [HW-1:0] base_term;
    logic [HW-1:0] idx_term;
    logic [HW-1:0] disp_term;
    logic          direct;

    assign direct = (md == MD_NODISP) && (rm == RM_DIR16);

    always_comb begin
        unique case (rm)
            3'd0, 3'd1, 3'd7: base_term = base_a;
            3'd2, 3'd3:       base_term = base_b;
            3'd6:             base_term = direct ? '0 : base_b;
            default:          base_term = '0;
        endcase
    end

    always_comb begin
        unique case (rm)
            3'd0, 3'd2, 3'd4: idx_term = idx_a;
            3'd1, 3'd3, 3'd5: idx_term = idx_b;
            default:          idx_term = '0;
        endcase
    end

    always_comb begin
        unique case (md)
            MD_DISP8: disp_term = {{(HW-8){disp_w[7]}}, disp_w[7:0]};
            MD_DISPW: disp_term = disp_w;
            default:  disp_term = direct ? disp_w : '0;
        endcase
    end

    assign ea = base_term + idx_term + disp_term;
endmodule

// File: rtl/eau_ea32.sv
module eau_ea32
    import eau_pkg::*;
(
    input  logic [1:0]                md,
    input  logic [2:0]                rm,
    input  logic [7:0]                sx,
    input  logic [DW-1:0]             disp,
    input  logic [NREG-1:0][DW-1:0]   regs,
    output logic [DW-1:0]             ea
);
    logic [2:0]    base_sel;
    logic          scaled;
    logic          no_base;
    logic          has_idx;
    logic [DW-1:0] base_term;
    logic [DW-1:0] idx_term;
    logic [DW-1:0] disp_term;

    assign scaled   = (rm == RM_SCALED);
    assign base_sel = scaled ? sx[2:0] : rm;
    assign no_base  = (md == MD_NODISP) && (base_sel == RM_NOBASE);
    assign has_idx  = scaled && (sx[5:3] != IX_NONE);

    assign base_term = no_base ? '0 : regs[base_sel];
    assign idx_term  = has_idx ? (regs[sx[5:3]] << sx[7:6]) : '0;

    always_comb begin
        unique case (md)
            MD_DISP8: disp_term = {{(DW-8){disp[7]}}, disp[7:0]};
            MD_DISPW: disp_term = disp;
            default:  disp_term = no_base ? disp : '0;
        endcase
    end

    assign ea = base_term + idx_term + disp_term;
endmodule

// File: rtl/eau_sizer.sv
module eau_sizer
    import eau_pkg::*;
(
    input  logic           op32,
    input  logic           addr32,
    input  logic [HW-1:0]  ea16,
    input  logic [DW-1:0]  ea32,
    input  logic [HW-1:0]  dest_hi,
    output logic [DW-1:0]  data,
    output logic [BEW-1:0] be
);
    logic [DW-1:0] wide;

    always_comb begin
        unique case ({op32, addr32})
            2'b11: begin
                wide = ea32;
            end
            2'b10: begin
                wide = {{(DW-HW){1'b0}}, ea16};
            end
            2'b01: begin
                wide = {{(DW-HW){1'b0}}, ea32[HW-1:0]};
            end
            default: begin
                wide = {{(DW-HW){1'b0}}, ea16};
            end
        endcase
    end

    assign data = op32 ? wide : {dest_hi, wide[HW-1:0]};
    assign be   = op32 ? {BEW{1'b1}} : {{(BEW/2){1'b0}}, {(BEW/2){1'b1}}};
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
    import eau_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 op32,
    input  logic                 addr32,
    input  logic [7:0]           mode_byte,
    input  logic [7:0]           sx_byte,
    input  logic [DW-1:0]        disp,
    input  logic [NREG*DW-1:0]   gpr_flat,
    output logic                 wr_valid,
    output logic [RIDX_W-1:0]    wr_idx,
    output logic [DW-1:0]        wr_data,
    output logic [BEW-1:0]       wr_be,
    output logic                 ud_fault
);
    logic [NREG-1:0][DW-1:0] regs;
    logic [1:0]              md;
    logic [2:0]              rm;
    logic [RIDX_W-1:0]       dst;
    logic [HW-1:0]           ea16;
    logic [DW-1:0]           ea32;
    logic [DW-1:0]           data_nx;
    logic [BEW-1:0]          be_nx;
    logic                    take_mem;
    logic                    take_reg;
    eau_state_e              state_q;
    eau_state_e              state_nx;

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_unpack
            assign regs[gi] = gpr_flat[gi*DW +: DW];
        end
    endgenerate

    assign md  = mode_byte[7:6];
    assign dst = mode_byte[5:3];
    assign rm  = mode_byte[2:0];

    assign take_mem = in_valid && (md != MD_REG);
    assign take_reg = in_valid && (md == MD_REG);

    eau_ea16 u_ea16 (
        .md     (md),
        .rm     (rm),
        .disp_w (disp[HW-1:0]),
        .base_a (regs[3][HW-1:0]),
        .base_b (regs[5][HW-1:0]),
        .idx_a  (regs[6][HW-1:0]),
        .idx_b  (regs[7][HW-1:0]),
        .ea     (ea16)
    );

    eau_ea32 u_ea32 (
        .md   (md),
        .rm   (rm),
        .sx   (sx_byte),
        .disp (disp),
        .regs (regs),
        .ea   (ea32)
    );

    eau_sizer u_sizer (
        .op32    (op32),
        .addr32  (addr32),
        .ea16    (ea16),
        .ea32    (ea32),
        .dest_hi (regs[dst][DW-1:HW]),
        .data    (data_nx),
        .be      (be_nx)
    );

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_FAULT: begin
                if (take_mem)      state_nx = ST_WRITE;
                else if (take_reg) state_nx = ST_FAULT;
                else               state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            wr_data <= '0;
            wr_be   <= '0;
        end else if (take_mem) begin
            wr_idx  <= dst;
            wr_data <= data_nx;
            wr_be   <= be_nx;
        end
    end

    always_comb begin
        wr_valid = 1'b0;
        ud_fault = 1'b0;
        unique case (state_q)
            ST_WRITE: wr_valid = 1'b1;
            ST_FAULT: ud_fault = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        op32,
    input logic        addr32,
    input logic [7:0]  mode_byte,
    input logic        wr_valid,
    input logic [2:0]  wr_idx,
    input logic [15:0] wr_hi,
    input logic [3:0]  wr_be,
    input logic        ud_fault
);
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && ($past(mode_byte[7:6]) != 2'b11)) |-> wr_valid);

    assert_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_idx == $past(mode_byte[5:3])));

    assert_zext_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(op32) && !$past(addr32)) |-> (wr_hi == 16'h0000));

    assert_be_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be == ($past(op32) ? 4'hF : 4'h3)));

    assert_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && ($past(mode_byte[7:6]) == 2'b11)) |-> (ud_fault && !wr_valid));

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && ud_fault));

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!wr_valid && !ud_fault));
endmodule

bind eff_addr_unit eff_addr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op32      (op32),
    .addr32    (addr32),
    .mode_byte (mode_byte),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .wr_hi     (wr_data[31:16]),
    .wr_be     (wr_be),
    .ud_fault  (ud_fault)
);

// File: tb/tb_eff_addr_unit.sv
`timescale 1ns/1ps
module tb_eff_addr_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op32 = 1'b0;
    logic         addr32 = 1'b0;
    logic [7:0]   mode_byte = 8'h00;
    logic [7:0]   sx_byte = 8'h00;
    logic [31:0]  disp = 32'h0;
    logic [255:0] gpr_flat;
    logic         wr_valid;
    logic [2:0]   wr_idx;
    logic [31:0]  wr_data;
    logic [3:0]   wr_be;
    logic         ud_fault;

    logic [31:0] r [8];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 8; k++) gpr_flat[k*32 +: 32] = r[k];
    end

    eff_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op32(op32), .addr32(addr32),
        .mode_byte(mode_byte), .sx_byte(sx_byte), .disp(disp), .gpr_flat(gpr_flat),
        .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
        .ud_fault(ud_fault)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] a16(input logic [7:0] m, input logic [31:0] d);
        logic [15:0] t, x;
        logic [1:0] md = m[7:6];
        case (m[2:0])
            3'd0: t = r[3][15:0] + r[6][15:0];
            3'd1: t = r[3][15:0] + r[7][15:0];
            3'd2: t = r[5][15:0] + r[6][15:0];
            3'd3: t = r[5][15:0] + r[7][15:0];
            3'd4: t = r[6][15:0];
            3'd5: t = r[7][15:0];
            3'd6: t = (md == 2'b00) ? 16'h0 : r[5][15:0];
            default: t = r[3][15:0];
        endcase
        if (md == 2'b01)      x = {{8{d[7]}}, d[7:0]};
        else if (md == 2'b10) x = d[15:0];
        else if (m[2:0] == 3'd6) x = d[15:0];
        else                  x = 16'h0;
        return t + x;
    endfunction

    function automatic logic [31:0] a32(input logic [7:0] m, input logic [7:0] s, input logic [31:0] d);
        logic [31:0] b, ix, x;
        logic [1:0] md = m[7:6];
        logic [2:0] bs = (m[2:0] == 3'd4) ? s[2:0] : m[2:0];
        bit nob = (md == 2'b00) && (bs == 3'd5);
        b  = nob ? 32'h0 : r[bs];
        ix = ((m[2:0] == 3'd4) && (s[5:3] != 3'd4)) ? r[s[5:3]] * (32'd1 << s[7:6]) : 32'h0;
        if (md == 2'b01)      x = {{24{d[7]}}, d[7:0]};
        else if (md == 2'b10) x = d;
        else if (nob)         x = d;
        else                  x = 32'h0;
        return b + ix + x;
    endfunction

    function automatic logic [31:0] model(input bit o, input bit a, input logic [7:0] m,
                                          input logic [7:0] s, input logic [31:0] d);
        logic [31:0] ea = a ? a32(m, s, d) : {16'h0, a16(m, d)};
        return o ? ea : {r[m[5:3]][31:16], ea[15:0]};
    endfunction

    task automatic run_one(input string req, input bit o, input bit a, input logic [7:0] m,
                           input logic [7:0] s, input logic [31:0] d);
        logic [31:0] exp = model(o, a, m, s, d);
        op32 = o; addr32 = a; mode_byte = m; sx_byte = s; disp = d; in_valid = 1'b1;
        @(negedge clk);
        chk("R2", "wr_valid", {31'h0, wr_valid}, 32'h1);
        chk("R3", "wr_idx", {29'h0, wr_idx}, {29'h0, m[5:3]});
        chk(req, "wr_data", wr_data, exp);
        chk("R10", "wr_be", {28'h0, wr_be}, o ? 32'hF : 32'h3);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "pulse end", {31'h0, wr_valid}, 32'h0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "wr_valid in reset", {31'h0, wr_valid}, 32'h0);
        chk("R1", "ud_fault in reset", {31'h0, ud_fault}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "wr_valid after reset", {31'h0, wr_valid}, 32'h0);
        chk("R1", "ud_fault after reset", {31'h0, ud_fault}, 32'h0);
    endtask

    task automatic t_ea16;
        for (int md = 0; md < 3; md++)
            for (int rm = 0; rm < 8; rm++)
                run_one((md == 0 && rm == 6) ? "R5" : "R4", 1'b0, 1'b0,
                        {md[1:0], 3'(rm + 1), rm[2:0]}, 8'h00, 32'h0000_8C93);
        r[3] = 32'h1234_FFF0; r[6] = 32'h0000_0020;
        run_one("R4", 1'b0, 1'b0, 8'b01_010_000, 8'h00, 32'h0000_00FF);
    endtask

    task automatic t_ea32;
        for (int md = 0; md < 3; md++)
            for (int rm = 0; rm < 8; rm++)
                if (rm != 4)
                    run_one("R6", 1'b1, 1'b1, {md[1:0], 3'(7 - rm), rm[2:0]}, 8'h00, 32'h8001_0081);
        r[0] = 32'hFFFF_FFF8;
        run_one("R6", 1'b1, 1'b1, 8'b01_001_000, 8'h00, 32'h0000_0010);
    endtask

    task automatic t_sib;
        for (int sc = 0; sc < 4; sc++)
            for (int ix = 0; ix < 8; ix += 2)
                for (int md = 0; md < 3; md++) begin
                    run_one("R7", 1'b1, 1'b1, {md[1:0], 3'd2, 3'd4},
                            {sc[1:0], ix[2:0], 3'd5}, 32'h0004_0100);
                    run_one("R7", 1'b1, 1'b1, {md[1:0], 3'd6, 3'd4},
                            {sc[1:0], 3'(ix + 1), 3'd1}, 32'hFFFF_FF80);
                end
    endtask

    task automatic t_op16_a32;
        run_one("R8", 1'b0, 1'b1, 8'b10_111_011, 8'h00, 32'h00AB_CDEF);
        run_one("R8", 1'b0, 1'b1, 8'b01_100_100, 8'hC8, 32'h0000_0077);
        run_one("R8", 1'b0, 1'b1, 8'b00_000_101, 8'h00, 32'hDEAD_BEEF);
    endtask

    task automatic t_op32_a16;
        run_one("R9", 1'b1, 1'b0, 8'b10_001_010, 8'h00, 32'hFFFF_F000);
        run_one("R9", 1'b1, 1'b0, 8'b00_011_110, 8'h00, 32'hAAAA_9876);
        run_one("R9", 1'b1, 1'b0, 8'b01_010_111, 8'h00, 32'h0000_0080);
    endtask

    task automatic t_fault;
        logic [31:0] keep = wr_data;
        op32 = 1'b1; addr32 = 1'b1; mode_byte = 8'b11_010_001; in_valid = 1'b1;
        @(negedge clk);
        chk("R11", "ud_fault", {31'h0, ud_fault}, 32'h1);
        chk("R11", "wr_valid", {31'h0, wr_valid}, 32'h0);
        chk("R11", "wr_data held", wr_data, keep);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11", "ud_fault end", {31'h0, ud_fault}, 32'h0);
    endtask

    task automatic t_idle;
        for (int k = 0; k < 6; k++) begin
            mode_byte = 8'(k * 8'h47); op32 = k[0]; addr32 = k[1]; in_valid = 1'b0;
            @(negedge clk);
            chk("R12", "wr_valid idle", {31'h0, wr_valid}, 32'h0);
            chk("R12", "ud_fault idle", {31'h0, ud_fault}, 32'h0);
        end
    endtask

    task automatic t_b2b;
        op32 = 1'b1; addr32 = 1'b1; mode_byte = 8'b10_000_011; disp = 32'h10; in_valid = 1'b1;
        @(negedge clk);
        chk("R2", "first pulse", {31'h0, wr_valid}, 32'h1);
        chk("R2", "first data", wr_data, r[3] + 32'h10);
        mode_byte = 8'b10_101_110; disp = 32'h20;
        @(negedge clk);
        chk("R2", "second pulse", {31'h0, wr_valid}, 32'h1);
        chk("R2", "second data", wr_data, r[6] + 32'h20);
        chk("R3", "second idx", {29'h0, wr_idx}, 32'h5);
        mode_byte = 8'b11_000_000;
        @(negedge clk);
        chk("R11", "fault after write", {30'h0, ud_fault, wr_valid}, 32'h2);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "all quiet", {30'h0, ud_fault, wr_valid}, 32'h0);
    endtask

    initial begin
        r[0] = 32'h0101_1111; r[1] = 32'h2222_0202; r[2] = 32'h3303_F333;
        r[3] = 32'h4404_0444; r[4] = 32'h5555_0505; r[5] = 32'hA6A6_8006;
        r[6] = 32'h7777_0707; r[7] = 32'hC8C8_FF08;
        t_reset();
        t_ea16();
        t_ea32();
        t_sib();
        t_op16_a32();
        t_op32_a16();
        t_fault();
        t_idle();
        t_b2b();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule